// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic read and write an external asynchronous byte-wide static RAM with 19 address bits. The host side is a plain request/acknowledge port that carries one transaction at a time. The controller latches the transaction and drives the active-low chip select, write enable and output enable strobes. It sequences them so that the address setup, write pulse, data hold and read access intervals are met. Each interval is a parameter counted in clock cycles, rounded up from the memory's nanosecond minimum at the chosen clock period.

A write holds the address with chip select low for a setup interval. It then lowers write enable for the pulse interval and drives the data bus. Chip select and write enable rise together, which ends the write. The controller keeps the address and the data on the bus for the hold interval after that edge. A read lowers chip select and output enable with write enable high, waits the access latency, and registers the bus on the last cycle of the wait. Each transaction ends with a single-cycle acknowledge. The data pins are split into an output, an output enable and an input, so that the pad ring or the bench can resolve them.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted, and immediately when it is asserted in the middle of a transaction, all three strobes are high, the data bus is released (`sram_dq_oe_o` = 0) and `ack_o` is 0.
- R2: On a write, chip select is low and the address is stable for at least SETUP_CYC samples before write enable falls. Write enable then stays low for PULSE_CYC cycles, with chip select low throughout.
- R3: On a write, the data bus is driven from the cycle in which write enable falls until HOLD_CYC cycles after the write ends. The address and the data stay unchanged during that time.
- R4: The byte that is written is stored at the latched address, and a later read of that address returns it.
- R5: On a read, chip select and output enable are low and write enable is high for RD_CYC cycles. `rdata_o` is registered from `sram_dq_i` on the last of those cycles.
- R6: The host sees `ack_o` high for exactly one cycle per transaction. It appears SETUP_CYC+PULSE_CYC+HOLD_CYC cycles after the accepting edge for a write, and RD_CYC cycles after it for a read.
- R7: The controller never drives the data bus while output enable is low. On the cycle before output enable falls, the bus is already released.
- R8: A request presented while a transaction is in progress is ignored: it produces no acknowledge and no memory access.
- R9: The address and write data are taken from the host inputs at acceptance. Later changes on `addr_i` and `wdata_i` do not affect the transaction in progress.
- R10: Write enable is low only while chip select is low, and write enable and output enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transaction request, sampled only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte address |
| wdata_i | input | DW | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data, valid with ack_o |
| sram_addr_o | output | AW | Memory address |
| sram_dq_o | output | DW | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | Data pad output enable |
| sram_dq_i | input | DW | Data returned by the memory |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |

## Verification
The behavioural memory in the bench returns a poison byte until output enable has been low with a stable address for the full latency. A controller that captures one cycle early therefore returns wrong read data. The memory model also counts setup samples, pulse length and the hold window, so a write enable that falls together with chip select, or a bus that is released at the write edge, is reported as a timing violation. The bench sends a second request while the controller is busy and changes the host address and data during a write. A controller that re-arms early gives a second acknowledge or writes a stray address, and one that does not latch its inputs stores the wrong byte. A reset applied in the middle of a write pulse must raise write enable at once; otherwise the write would be left open.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ack;
  } strobe_t;

  function automatic strobe_t decode_strobe(state_e s);
    strobe_t r;
    r.cs_n  = !(s == ST_WSETUP || s == ST_WPULSE || s == ST_RACC);
    r.we_n  = (s != ST_WPULSE);
    r.oe_n  = (s != ST_RACC);
    r.dq_oe = (s == ST_WPULSE || s == ST_WHOLD);
    r.ack   = (s == ST_DONE);
    return r;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned RD_CYC    = 2,
  parameter int unsigned CW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          cs_no,
  output logic          we_no,
  output logic          oe_no,
  output logic          dq_oe_o,
  output logic          ack_o
);

  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_PULSE = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] L_HOLD  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);

  state_e  st_q, st_d;
  strobe_t strb_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (we_i) begin
          st_d       = ST_WSETUP;
          load_val_o = L_SETUP;
        end else begin
          st_d       = ST_RACC;
          load_val_o = L_RD;
        end
      end
      ST_WSETUP: if (zero_i) begin
        st_d       = ST_WPULSE;
        load_o     = 1'b1;
        load_val_o = L_PULSE;
      end
      ST_WPULSE: if (zero_i) begin
        st_d       = ST_WHOLD;
        load_o     = 1'b1;
        load_val_o = L_HOLD;
      end
      ST_WHOLD: if (zero_i) st_d = ST_DONE;
      ST_RACC: if (zero_i) begin
        st_d      = ST_DONE;
        capture_o = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: glitch-free pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      strb_q <= decode_strobe(ST_IDLE);
    end else begin
      st_q   <= st_d;
      strb_q <= decode_strobe(st_d);
    end
  end

  assign cs_no   = strb_q.cs_n;
  assign we_no   = strb_q.we_n;
  assign oe_no   = strb_q.oe_n;
  assign dq_oe_o = strb_q.dq_oe;
  assign ack_o   = strb_q.ack;

  a_r10_we_inside_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);
  a_r10_we_oe_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !oe_no));
  a_r7_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !dq_oe_o);
  a_r7_release_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_no) |-> !$past(dq_oe_o));
  a_r6_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r3_drive_covers_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> dq_oe_o);
  a_r8_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no || dq_oe_o) |-> !accept_o);

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] sram_dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= sram_dq_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int unsigned AW        = 19,
  parameter int unsigned DW        = 8,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned RD_CYC    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_cs_no,
  output logic          sram_we_no,
  output logic          sram_oe_no
);

  localparam int unsigned MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_CD = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int unsigned MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic          load, zero, accept, capture;
  logic [CW-1:0] load_val;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_ctrl_seq #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .RD_CYC    (RD_CYC),
    .CW        (CW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .cs_no      (sram_cs_no),
    .we_no      (sram_we_no),
    .oe_no      (sram_oe_no),
    .dq_oe_o    (sram_dq_oe_o),
    .ack_o      (ack_o)
  );

  sram_ctrl_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .sram_dq_i (sram_dq_i),
    .addr_o    (sram_addr_o),
    .wdata_o   (sram_dq_o),
    .rdata_o   (rdata_o)
  );

  a_r9_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!sram_cs_no || sram_dq_oe_o) && $past(!sram_cs_no || sram_dq_oe_o))
      |-> $stable(sram_addr_o));
  a_r3_wdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

endmodule

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;

  localparam int AW = 19, DW = 8;
  localparam int SETUP_CYC = 1, PULSE_CYC = 2, HOLD_CYC = 1, RD_CYC = 2;
  localparam int WR_LAT = SETUP_CYC + PULSE_CYC + HOLD_CYC;
  localparam int NVEC = 10;
  // {we, addr, data}: for reads, data is the expected byte
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 8'h3C}, {1'b1, 19'h7FFFF, 8'hA5}, {1'b1, 19'h40000, 8'h5A},
    {1'b0, 19'h00000, 8'h3C}, {1'b0, 19'h7FFFF, 8'hA5}, {1'b1, 19'h12345, 8'hC3},
    {1'b0, 19'h40000, 8'h5A}, {1'b0, 19'h12345, 8'hC3}, {1'b1, 19'h00000, 8'h0F},
    {1'b0, 19'h00000, 8'h0F}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ack, dq_oe, cs_n, we_n, oe_n;
  logic [DW-1:0] rdata, dq_o;
  logic [DW-1:0] dq_i = 8'hEE;
  logic [AW-1:0] s_addr;

  int checks = 0, errors = 0;
  int viol_r2 = 0, viol_r3 = 0, viol_r7 = 0, viol_r10 = 0;

  always #5 clk = ~clk;

  sram_ctrl #(
    .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .RD_CYC(RD_CYC)
  ) u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i),
    .sram_cs_no(cs_n), .sram_we_no(we_n), .sram_oe_no(oe_n)
  );

  // behavioural memory with timing monitor, sampled mid-cycle
  logic [7:0] mem [int unsigned];
  logic p_cs = 1, p_we = 1, p_oe = 1, p_dqoe = 0;
  logic [AW-1:0] p_addr = '0, h_addr = '0;
  logic [DW-1:0] p_dq = '0, h_dq = '0;
  int stab = 0, pulse = 0, hold_left = 0, rd_cnt = 0;

  function automatic logic [7:0] mem_rd(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) begin
      p_cs = 1; p_we = 1; p_oe = 1; p_dqoe = 0;
      stab = 0; pulse = 0; hold_left = 0; rd_cnt = 0; dq_i = 8'hEE;
    end else begin
      if (!cs_n) stab = (!p_cs && s_addr == p_addr) ? stab + 1 : 1;
      else stab = 0;
      if (p_we && !we_n) begin
        if (cs_n || stab <= SETUP_CYC) viol_r2++;
        pulse = 1;
      end else if (!we_n) pulse++;
      if (!we_n && (!dq_oe || (!p_we && dq_o != p_dq))) viol_r3++;
      if (!p_we && !p_cs && (we_n || cs_n)) begin
        if (pulse < PULSE_CYC) viol_r2++;
        mem[int'(p_addr)] = p_dq;
        hold_left = HOLD_CYC; h_addr = p_addr; h_dq = p_dq;
      end
      if (hold_left > 0) begin
        if (!dq_oe || s_addr != h_addr || dq_o != h_dq) viol_r3++;
        hold_left--;
      end
      if (!cs_n && !oe_n && we_n)
        rd_cnt = (!p_cs && !p_oe && s_addr == p_addr) ? rd_cnt + 1 : 1;
      else rd_cnt = 0;
      dq_i = (rd_cnt >= RD_CYC) ? mem_rd(s_addr) : 8'hEE;
      if (dq_oe && !oe_n) viol_r7++;
      if (p_oe && !oe_n && p_dqoe) viol_r7++;
      if (!we_n && (cs_n || !oe_n)) viol_r10++;
      p_cs = cs_n; p_we = we_n; p_oe = oe_n; p_dqoe = dq_oe;
      p_addr = s_addr; p_dq = dq_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (!ack && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic txn(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string tag);
    int n;
    start(w, a, d);
    wait_ack(n);
    chk({tag, " R6 latency"}, n, w ? WR_LAT : RD_CYC);
    if (!w) chk({tag, " R5 R4 read data"}, rdata, d);
    @(negedge clk);
    chk({tag, " R6 ack one cycle"}, ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, acks;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1); chk("R1 we_n", we_n, 1); chk("R1 oe_n", oe_n, 1);
    chk("R1 dq_oe", dq_oe, 0); chk("R1 ack", ack, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      txn(VEC[i][27], VEC[i][26:8], VEC[i][7:0], $sformatf("vec%0d", i));

    // R8: second request while busy
    start(1, 19'h00100, 8'h11);
    req = 1; we = 1; addr = 19'h00200; wdata = 8'h22;
    @(negedge clk);
    req = 0;
    acks = 0;
    for (int i = 0; i < 10; i++) begin
      if (ack) acks++;
      @(negedge clk);
    end
    chk("R8 single ack for busy request", acks, 1);
    txn(0, 19'h00200, 8'h00, "R8 ignored address untouched");
    txn(0, 19'h00100, 8'h11, "R8 first write kept");

    // R9: host inputs change after acceptance
    start(1, 19'h00300, 8'h33);
    acks = 0;
    for (int i = 0; i < 8; i++) begin
      addr = 19'h00301 + 19'(i); wdata = 8'(i);
      if (ack) acks++;
      @(negedge clk);
    end
    chk("R9 one ack", acks, 1);
    txn(0, 19'h00300, 8'h33, "R9 latched data");
    txn(0, 19'h00301, 8'h00, "R9 no stray write");

    // R1: reset during write pulse
    start(1, 19'h00400, 8'h44);
    @(negedge clk);
    chk("R1 mid pulse we_n low", we_n, 0);
    rst_ni = 0;
    #1;
    chk("R1 async we_n", we_n, 1); chk("R1 async cs_n", cs_n, 1);
    chk("R1 async dq_oe", dq_oe, 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    txn(0, 19'h12345, 8'hC3, "R1 after reset read");

    chk("R2 setup/pulse violations", viol_r2, 0);
    chk("R3 hold/drive violations", viol_r3, 0);
    chk("R7 bus contention events", viol_r7, 0);
    chk("R10 strobe combination violations", viol_r10, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule